// File: doc/BRIEF.md
# SPI Register Front End for a Two-Port I/O Expander

This block is the serial register interface of a 16-bit I/O expander with two 8-bit ports, called A and B. A host talks to it as an SPI target in mode 0: the serial clock idles low, the target samples its input on the rising edge and changes its output on the falling edge. Every frame opens with a control byte, which selects the device and gives the direction of the access. A register pointer byte follows. After that come one or more data bytes, which are either written into the register file or shifted out of it, most significant bit first. The SPI lines are brought into the system clock domain through synchronizer flops. Edge detection then runs on the synchronized serial clock, so the serial clock must be several times slower than the system clock.

The register file keeps the per-port direction, input polarity, pull-up and output latch bytes. It also keeps the interrupt enable, compare and control bytes, which the interrupt logic elsewhere uses, and one shared configuration byte. The interrupt flags and capture values come in from outside and can only be read. Reading a port returns the pins after the polarity inversion. Writing a port loads its output latch. After a data byte the pointer normally moves to the next register. A configuration bit stops this, so that one register can be polled or streamed.

Top module: `spi_ioexp_regif`

## Requirements
- R1: The control byte carries 0100 in bits 7:4, a device address in bits 3:1 and the direction in bit 0 (1 = read, 0 = write). If the upper four bits are not 0100, the rest of the frame is ignored: no register changes and `miso_oe` stays low until `cs_n` goes high.
- R2: When configuration bit 3 is 1, control-byte bits 3:1 must equal `strap_addr`, or else the frame is ignored as in R1. When that bit is 0, bits 3:1 are not compared.
- R3: A write frame of three bytes (control, pointer, data) stores the data byte in the register the pointer selects. The interleaved map uses port A at the even address and port B at the odd address. Direction is at 0x00/0x01, polarity 0x02/0x03, interrupt enable 0x04/0x05, compare value 0x06/0x07, interrupt control 0x08/0x09, pull-up 0x0C/0x0D, flags 0x0E/0x0F, capture 0x10/0x11, port 0x12/0x13 and output latch 0x14/0x15.
- R4: In a read frame the register value is shifted out on `miso`, MSB first, during the third byte. `miso_oe` is low during the control and pointer bytes and during every write frame, and high through the data bytes of a read.
- R5: When configuration bit 5 is 0, the pointer moves forward by one after each data byte, and it wraps from 0x15 to 0x00. This holds for both reads and writes.
- R6: When configuration bit 5 is 1, the pointer stays where it is, so every data byte of the frame goes to the same register.
- R7: The configuration byte is reached at both 0x0A and 0x0B, and both addresses hold the same storage. Its bit 0 always reads 0. Bit 7 is stored but has no effect, because only the interleaved layout exists.
- R8: Reading 0x12/0x13 returns the port's `pin_in` byte XOR its polarity byte. Writing 0x12/0x13 updates that port's output latch, which is also visible at 0x14/0x15.
- R9: Pointer values above 0x15 read as 0x00, and a write to them changes nothing.
- R10: After reset both direction bytes are 0xFF, every other stored register is 0x00, and `miso_oe` is low.
- R11: The flag (0x0E/0x0F) and capture (0x10/0x11) addresses return `intf_in` and `intcap_in`, and writes to them are ignored.
- R12: The pointer step that follows a data byte uses the configuration value in force before that byte. A byte that writes configuration bit 5 changes the pointer behaviour only from the next data byte on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the miso pad driver |
| strap_addr | input | 3 | Device address set by board straps |
| pin_in | input | 16 | Pad input levels, port A in [7:0], port B in [15:8] |
| intf_in | input | 16 | Interrupt flag values from the interrupt logic |
| intcap_in | input | 16 | Interrupt capture values from the interrupt logic |
| dir_o | output | 16 | Direction bytes (1 = input) |
| pol_o | output | 16 | Input polarity bytes |
| pullup_o | output | 16 | Pull-up enable bytes |
| olat_o | output | 16 | Output latch bytes |
| inten_o | output | 16 | Interrupt enable bytes |
| defval_o | output | 16 | Interrupt compare value bytes |
| intctl_o | output | 16 | Interrupt control bytes |
| cfg_o | output | 8 | Configuration byte |

## Verification
The hard case is a data byte that writes the configuration register in the middle of a burst. In the same clock edge, the configuration storage takes the new value and the pointer decides whether to advance. The bench sends two-byte bursts that start at 0x0B. One burst sets the hold bit and one clears it. The result is judged at the ports: the bench checks whether the second byte reached the configuration byte or the next-door pull-up byte. Each of the two outcomes matches only one possible ordering, so the bench can tell which ordering the design used.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;

    localparam int          NUM_PORTS   = 2;
    localparam int          BYTE_W      = 8;
    localparam int          PIN_W       = NUM_PORTS * BYTE_W;
    localparam logic [7:0]  LAST_REG    = 8'h15;
    localparam logic [3:0]  CTRL_PREFIX = 4'b0100;
    localparam int          CFG_HOLD_B  = 5;
    localparam int          CFG_MATCH_B = 3;
    localparam int          CFG_ZERO_B  = 0;

    typedef enum logic [1:0] {
        PH_CTRL,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef enum logic [3:0] {
        RK_DIR, RK_POL, RK_INTEN, RK_DEFV, RK_INTCTL, RK_CFG,
        RK_PULL, RK_FLAG, RK_CAP, RK_PORT, RK_OLAT, RK_NONE
    } reg_kind_e;

    typedef struct packed {
        logic [3:0] prefix;
        logic [2:0] hw;
        logic       rd;
    } ctrl_byte_t;

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] pol;
        logic [7:0] inten;
        logic [7:0] defv;
        logic [7:0] intctl;
        logic [7:0] pull;
        logic [7:0] olat;
    } port_regs_t;

    // Pair index in bits 4:1 picks the register kind, bit 0 picks the port.
    function automatic reg_kind_e decode_kind(input logic [7:0] a);
        reg_kind_e k;
        if (a > LAST_REG) begin
            k = RK_NONE;
        end else begin
            case (a[4:1])
                4'd0:    k = RK_DIR;
                4'd1:    k = RK_POL;
                4'd2:    k = RK_INTEN;
                4'd3:    k = RK_DEFV;
                4'd4:    k = RK_INTCTL;
                4'd5:    k = RK_CFG;
                4'd6:    k = RK_PULL;
                4'd7:    k = RK_FLAG;
                4'd8:    k = RK_CAP;
                4'd9:    k = RK_PORT;
                4'd10:   k = RK_OLAT;
                default: k = RK_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic logic [7:0] next_ptr(input logic [7:0] a);
        return (a == LAST_REG) ? 8'h00 : a + 8'h01;
    endfunction

    function automatic logic ctrl_accept(input ctrl_byte_t c,
                                         input logic [2:0] strap,
                                         input logic match_en);
        return (c.prefix == CTRL_PREFIX) && (!match_en || (c.hw == strap));
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_active,
    output logic mosi_s
);

    logic [STAGES-1:0] sck_sr;
    logic [STAGES-1:0] cs_sr;
    logic [STAGES-1:0] mosi_sr;
    logic              sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sr  <= '0;
            cs_sr   <= '1;
            mosi_sr <= '0;
            sck_d   <= 1'b0;
        end else begin
            sck_sr  <= {sck_sr[STAGES-2:0], sck};
            cs_sr   <= {cs_sr[STAGES-2:0], cs_n};
            mosi_sr <= {mosi_sr[STAGES-2:0], mosi};
            sck_d   <= sck_sr[STAGES-1];
        end
    end

    assign sck_rise  =  sck_sr[STAGES-1] & ~sck_d;
    assign sck_fall  = ~sck_sr[STAGES-1] &  sck_d;
    assign cs_active = ~cs_sr[STAGES-1];
    assign mosi_s    =  mosi_sr[STAGES-1];

    initial begin
        if (STAGES < 2) $error("spi_in_sync needs at least two stages");
    end

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import ioexp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       cs_active,
    input  logic       mosi_s,
    input  logic [2:0] strap,
    input  logic       cfg_hold,
    input  logic       cfg_match,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       miso,
    output logic       miso_oe
);

    phase_e     phase;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic       rd_op;
    logic [7:0] ptr;
    logic [7:0] tx_sr;
    logic       load_pend;
    logic       oe_r;

    logic [7:0] byte_in;
    logic       byte_done;
    ctrl_byte_t ctrl;

    assign byte_in   = {rx_sr, mosi_s};
    assign byte_done = sck_rise && (bit_cnt == 3'd7);
    assign ctrl      = ctrl_byte_t'(byte_in);

    always_ff @(posedge clk) begin
        if (rst || !cs_active) begin
            phase     <= PH_CTRL;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            rd_op     <= 1'b0;
            tx_sr     <= '0;
            load_pend <= 1'b0;
            oe_r      <= 1'b0;
        end else begin
            if (sck_rise) begin
                rx_sr   <= byte_in[6:0];
                bit_cnt <= bit_cnt + 3'd1;
            end
            load_pend <= 1'b0;
            if (byte_done) begin
                case (phase)
                    PH_CTRL: begin
                        if (ctrl_accept(ctrl, strap, cfg_match)) begin
                            phase <= PH_ADDR;
                            rd_op <= ctrl.rd;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_ADDR: begin
                        phase     <= PH_DATA;
                        load_pend <= rd_op;
                    end
                    PH_DATA: load_pend <= rd_op;
                    default: ;
                endcase
            end
            if (load_pend) begin
                tx_sr <= rd_data;
                oe_r  <= 1'b1;
            end else if (sck_fall && oe_r && (bit_cnt != 3'd0)) begin
                tx_sr <= {tx_sr[6:0], 1'b0};
            end
        end
    end

    // Pointer survives chip-select release; the step uses the stored config.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (cs_active && byte_done) begin
            if (phase == PH_ADDR) begin
                ptr <= byte_in;
            end else if ((phase == PH_DATA) && !cfg_hold) begin
                ptr <= next_ptr(ptr);
            end
        end
    end

    assign rd_addr = ptr;
    assign wr_addr = ptr;
    assign wr_data = byte_in;
    assign wr_en   = byte_done && (phase == PH_DATA) && !rd_op;
    assign miso    = tx_sr[7];
    assign miso_oe = oe_r;

    a_r4_oe_only_read_data: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> ((phase == PH_DATA) && rd_op));

    a_r1_skip_sticky: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |=> ((phase == PH_SKIP) || (phase == PH_CTRL)));

    a_r1_no_write_when_skipped: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !wr_en);

    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (cs_active && byte_done && (phase == PH_DATA) && cfg_hold) |=> $stable(ptr));

    a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        (cs_active && byte_done && (phase == PH_DATA) && !cfg_hold && (ptr == LAST_REG))
        |=> (ptr == 8'h00));

endmodule

// File: rtl/ioexp_regfile.sv
module ioexp_regfile
    import ioexp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [7:0]       rd_addr,
    output logic [7:0]       rd_data,
    input  logic [PIN_W-1:0] pin_in,
    input  logic [PIN_W-1:0] intf_in,
    input  logic [PIN_W-1:0] intcap_in,
    output logic [PIN_W-1:0] dir_o,
    output logic [PIN_W-1:0] pol_o,
    output logic [PIN_W-1:0] pullup_o,
    output logic [PIN_W-1:0] olat_o,
    output logic [PIN_W-1:0] inten_o,
    output logic [PIN_W-1:0] defval_o,
    output logic [PIN_W-1:0] intctl_o,
    output logic [7:0]       cfg_o
);

    localparam logic [7:0] CFG_KEEP = ~(8'h01 << CFG_ZERO_B);

    reg_kind_e  wr_kind;
    reg_kind_e  rd_kind;
    logic [7:0] cfg_q;
    logic [7:0] port_rd [NUM_PORTS];

    assign wr_kind = decode_kind(wr_addr);
    assign rd_kind = decode_kind(rd_addr);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_regs_t regs_q;
        logic       sel_wr;

        assign sel_wr = wr_en && (wr_addr[0] == 1'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q     <= '0;
                regs_q.dir <= 8'hFF;
            end else if (sel_wr) begin
                case (wr_kind)
                    RK_DIR:          regs_q.dir    <= wr_data;
                    RK_POL:          regs_q.pol    <= wr_data;
                    RK_INTEN:        regs_q.inten  <= wr_data;
                    RK_DEFV:         regs_q.defv   <= wr_data;
                    RK_INTCTL:       regs_q.intctl <= wr_data;
                    RK_PULL:         regs_q.pull   <= wr_data;
                    RK_PORT, RK_OLAT: regs_q.olat  <= wr_data;
                    default: ;
                endcase
            end
        end

        always_comb begin
            case (rd_kind)
                RK_DIR:    port_rd[p] = regs_q.dir;
                RK_POL:    port_rd[p] = regs_q.pol;
                RK_INTEN:  port_rd[p] = regs_q.inten;
                RK_DEFV:   port_rd[p] = regs_q.defv;
                RK_INTCTL: port_rd[p] = regs_q.intctl;
                RK_PULL:   port_rd[p] = regs_q.pull;
                RK_FLAG:   port_rd[p] = intf_in[p*BYTE_W +: BYTE_W];
                RK_CAP:    port_rd[p] = intcap_in[p*BYTE_W +: BYTE_W];
                RK_PORT:   port_rd[p] = pin_in[p*BYTE_W +: BYTE_W] ^ regs_q.pol;
                RK_OLAT:   port_rd[p] = regs_q.olat;
                default:   port_rd[p] = 8'h00;
            endcase
        end

        assign dir_o   [p*BYTE_W +: BYTE_W] = regs_q.dir;
        assign pol_o   [p*BYTE_W +: BYTE_W] = regs_q.pol;
        assign pullup_o[p*BYTE_W +: BYTE_W] = regs_q.pull;
        assign olat_o  [p*BYTE_W +: BYTE_W] = regs_q.olat;
        assign inten_o [p*BYTE_W +: BYTE_W] = regs_q.inten;
        assign defval_o[p*BYTE_W +: BYTE_W] = regs_q.defv;
        assign intctl_o[p*BYTE_W +: BYTE_W] = regs_q.intctl;
    end

    // Both aliases of the configuration byte land here.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en && (wr_kind == RK_CFG)) begin
            cfg_q <= wr_data & CFG_KEEP;
        end
    end

    always_comb begin
        case (rd_kind)
            RK_CFG:  rd_data = cfg_q;
            RK_NONE: rd_data = 8'h00;
            default: rd_data = port_rd[rd_addr[0]];
        endcase
    end

    assign cfg_o = cfg_q;

    a_r7_unimp_bit_zero: assert property (@(posedge clk) disable iff (rst)
        !cfg_o[CFG_ZERO_B]);

    a_r9_oob_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_addr > LAST_REG) |-> (rd_data == 8'h00));

    a_r9_oob_write_no_effect: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr > LAST_REG)) |=>
        ($stable(olat_o) && $stable(dir_o) && $stable(pol_o) && $stable(cfg_o)));

    a_r11_flag_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ((wr_kind == RK_FLAG) || (wr_kind == RK_CAP))) |=>
        ($stable(olat_o) && $stable(pullup_o) && $stable(cfg_o)));

    a_r10_reset_values: assert property (@(posedge clk)
        $past(rst) |-> ((dir_o == '1) && (olat_o == '0) && (cfg_o == 8'h00)));

endmodule

// File: rtl/spi_ioexp_regif.sv
module spi_ioexp_regif
    import ioexp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sck,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        miso,
    output logic        miso_oe,
    input  logic [2:0]  strap_addr,
    input  logic [15:0] pin_in,
    input  logic [15:0] intf_in,
    input  logic [15:0] intcap_in,
    output logic [15:0] dir_o,
    output logic [15:0] pol_o,
    output logic [15:0] pullup_o,
    output logic [15:0] olat_o,
    output logic [15:0] inten_o,
    output logic [15:0] defval_o,
    output logic [15:0] intctl_o,
    output logic [7:0]  cfg_o
);

    logic       sck_rise;
    logic       sck_fall;
    logic       cs_active;
    logic       mosi_s;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] cfg_q;

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sck       (sck),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s)
    );

    spi_frame_ctrl u_frame (
        .clk       (clk),
        .rst       (rst),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s),
        .strap     (strap_addr),
        .cfg_hold  (cfg_q[CFG_HOLD_B]),
        .cfg_match (cfg_q[CFG_MATCH_B]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .miso      (miso),
        .miso_oe   (miso_oe)
    );

    ioexp_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .pin_in    (pin_in),
        .intf_in   (intf_in),
        .intcap_in (intcap_in),
        .dir_o     (dir_o),
        .pol_o     (pol_o),
        .pullup_o  (pullup_o),
        .olat_o    (olat_o),
        .inten_o   (inten_o),
        .defval_o  (defval_o),
        .intctl_o  (intctl_o),
        .cfg_o     (cfg_q)
    );

    assign cfg_o = cfg_q;

endmodule

// File: tb/spi_ioexp_regif_tb.sv
module spi_ioexp_regif_tb_top;

    localparam int HALF   = 8;
    localparam int NVEC   = 30;
    localparam logic [2:0] MY_HW = 3'b101;
    localparam logic [2:0] OTHER_HW = 3'b010;

    // {read, pointer, data-or-expected}
    localparam logic [16:0] VECS [NVEC] = '{
        {1'b1, 8'h00, 8'hFF}, {1'b1, 8'h01, 8'hFF}, {1'b1, 8'h02, 8'h00},
        {1'b1, 8'h0C, 8'h00}, {1'b0, 8'h00, 8'h0F}, {1'b1, 8'h00, 8'h0F},
        {1'b0, 8'h03, 8'hFF}, {1'b1, 8'h13, 8'h5A}, {1'b1, 8'h12, 8'h5A},
        {1'b0, 8'h12, 8'h3C}, {1'b1, 8'h14, 8'h3C}, {1'b0, 8'h15, 8'hC3},
        {1'b1, 8'h15, 8'hC3}, {1'b1, 8'h13, 8'h5A}, {1'b0, 8'h0E, 8'h77},
        {1'b1, 8'h0E, 8'h00}, {1'b1, 8'h0F, 8'h0F}, {1'b1, 8'h10, 8'h34},
        {1'b1, 8'h11, 8'h12}, {1'b0, 8'h0A, 8'h01}, {1'b1, 8'h0B, 8'h00},
        {1'b0, 8'h0B, 8'h41}, {1'b1, 8'h0A, 8'h40}, {1'b0, 8'h0A, 8'h00},
        {1'b1, 8'h0A, 8'h00}, {1'b0, 8'h16, 8'h99}, {1'b1, 8'h16, 8'h00},
        {1'b1, 8'h7F, 8'h00}, {1'b0, 8'h07, 8'h5A}, {1'b1, 8'h07, 8'h5A}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        miso_oe;
    logic [2:0]  strap_addr = MY_HW;
    logic [15:0] pin_in = 16'hA55A;
    logic [15:0] intf_in = 16'h0F00;
    logic [15:0] intcap_in = 16'h1234;
    logic [15:0] dir_o, pol_o, pullup_o, olat_o, inten_o, defval_o, intctl_o;
    logic [7:0]  cfg_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_ioexp_regif dut_i (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .strap_addr(strap_addr),
        .pin_in(pin_in), .intf_in(intf_in), .intcap_in(intcap_in),
        .dir_o(dir_o), .pol_o(pol_o), .pullup_o(pullup_o), .olat_o(olat_o),
        .inten_o(inten_o), .defval_o(defval_o), .intctl_o(intctl_o),
        .cfg_o(cfg_o)
    );

    function automatic logic [7:0] ctl(input logic [2:0] hw, input logic rd);
        return {4'b0100, hw, rd};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic [7:0] oe);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            oe[i] = miso_oe;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    // Frame of: ctrl, pointer, then n bytes from dd (byte i at dd[8*i+:8]).
    task automatic frame(input logic [7:0] c, input logic [7:0] a, input int n,
                         input logic [31:0] dd, output logic [31:0] qq,
                         output logic [7:0] oe_hdr, output logic [31:0] oe_dat);
        logic [7:0] rx, oe1, oe2;
        qq = '0;
        oe_dat = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        xfer(c, rx, oe1);
        xfer(a, rx, oe2);
        oe_hdr = oe1 | oe2;
        for (int i = 0; i < n; i++) begin
            xfer(dd[8*i +: 8], rx, oe1);
            qq[8*i +: 8] = rx;
            oe_dat[8*i +: 8] = oe1;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic wr1(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d,
                       output logic any_oe);
        logic [31:0] q, od;
        logic [7:0]  oh;
        frame(c, a, 1, {24'h0, d}, q, oh, od);
        any_oe = |oh || |od;
    endtask

    task automatic rd1(input logic [7:0] c, input logic [7:0] a, output logic [7:0] d,
                       output logic [7:0] oe_hdr, output logic [7:0] oe_dat);
        logic [31:0] q, od;
        frame(c, a, 1, 32'h0, q, oe_hdr, od);
        d = q[7:0];
        oe_dat = od[7:0];
    endtask

    task automatic print_summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        print_summary();
        $finish;
    end

    initial begin
        logic [7:0]  d, oh, od;
        logic [31:0] q, odat;
        logic        any;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R10: reset state at the ports
        check("R10 dir reset", dir_o, 16'hFFFF);
        check("R10 olat/pol reset", {olat_o, pol_o}, 32'h0);
        check("R10 cfg reset", cfg_o, 8'h00);
        check("R10 oe reset", miso_oe, 1'b0);

        // Table walk: R3, R7, R8, R9, R10, R11 single accesses
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v][16]) begin
                rd1(ctl(MY_HW, 1'b1), VECS[v][15:8], d, oh, od);
                check($sformatf("R3/R7/R8/R9/R11 table read %0d ptr %h", v, VECS[v][15:8]),
                      d, VECS[v][7:0]);
            end else begin
                wr1(ctl(MY_HW, 1'b0), VECS[v][15:8], VECS[v][7:0], any);
                check($sformatf("R4 write frame oe %0d", v), any, 1'b0);
            end
        end
        check("R3 dir ports", dir_o, 16'hFF0F);
        check("R3 pol ports", pol_o, 16'hFF00);
        check("R8 olat ports", olat_o, 16'hC33C);
        check("R9 no alias of 0x16", {pullup_o, intctl_o}, 32'h0);
        check("R3 compare ports", defval_o, 16'h5A00);

        // R8: port B write loads its latch
        wr1(ctl(MY_HW, 1'b0), 8'h13, 8'h77, any);
        check("R8 port write to latch", olat_o, 16'h773C);

        // R4: output enable profile on a read
        rd1(ctl(MY_HW, 1'b1), 8'h00, d, oh, od);
        check("R4 oe during header", oh, 8'h00);
        check("R4 oe during data", od, 8'hFF);
        check("R4 data MSB first", d, 8'h0F);

        // R5: sequential read with wrap 0x15 -> 0x00
        frame(ctl(MY_HW, 1'b1), 8'h14, 4, 32'h0, q, oh, odat);
        check("R5 burst read wrap", q, 32'hFF0F_773C);
        frame(ctl(MY_HW, 1'b0), 8'h04, 2, 32'h0000_2211, q, oh, odat);
        check("R5 burst write", inten_o, 16'h2211);
        frame(ctl(MY_HW, 1'b0), 8'h15, 2, 32'h0000_1F77, q, oh, odat);
        check("R5 write wraps to dir A", dir_o, 16'hFF1F);

        // R6: hold bit keeps the pointer
        wr1(ctl(MY_HW, 1'b0), 8'h0A, 8'h20, any);
        check("R6 cfg set", cfg_o, 8'h20);
        frame(ctl(MY_HW, 1'b1), 8'h14, 3, 32'h0, q, oh, odat);
        check("R6 burst read holds", q[23:0], 24'h3C3C3C);
        frame(ctl(MY_HW, 1'b0), 8'h06, 2, 32'h0000_0201, q, oh, odat);
        check("R6 burst write holds", defval_o, 16'h5A02);

        // R12: step after a config write uses the old value (hold was 1)
        frame(ctl(MY_HW, 1'b0), 8'h0B, 2, 32'h0000_2400, q, oh, odat);
        check("R12 held on config clear", cfg_o, 8'h24);
        check("R12 neighbour untouched", pullup_o, 16'h0000);
        wr1(ctl(MY_HW, 1'b0), 8'h0A, 8'h00, any);
        // R12: hold was 0, so the second byte moves on to 0x0C
        frame(ctl(MY_HW, 1'b0), 8'h0B, 2, 32'h0000_3C20, q, oh, odat);
        check("R12 stepped on config set", cfg_o, 8'h20);
        check("R12 second byte in pull-up A", pullup_o, 16'h003C);
        wr1(ctl(MY_HW, 1'b0), 8'h0A, 8'h00, any);

        // R2: address matching off, then on
        wr1(ctl(OTHER_HW, 1'b0), 8'h02, 8'h81, any);
        check("R2 mismatch accepted when off", pol_o, 16'hFF81);
        wr1(ctl(MY_HW, 1'b0), 8'h0A, 8'h08, any);
        wr1(ctl(OTHER_HW, 1'b0), 8'h02, 8'h18, any);
        check("R2 mismatch write ignored", pol_o, 16'hFF81);
        rd1(ctl(OTHER_HW, 1'b1), 8'h02, d, oh, od);
        check("R2 mismatch read no drive", {oh, od}, 16'h0000);
        wr1(ctl(MY_HW, 1'b0), 8'h02, 8'h18, any);
        check("R2 match accepted", pol_o, 16'hFF18);
        wr1(ctl(MY_HW, 1'b0), 8'h0A, 8'h00, any);

        // R1: bad prefix frames are ignored
        wr1({4'b0101, MY_HW, 1'b0}, 8'h02, 8'h00, any);
        check("R1 bad prefix write ignored", pol_o, 16'hFF18);
        rd1({4'b1100, MY_HW, 1'b1}, 8'h02, d, oh, od);
        check("R1 bad prefix read no drive", {oh, od}, 16'h0000);
        rd1(ctl(MY_HW, 1'b1), 8'h02, d, oh, od);
        check("R1 good frame after bad", d, 8'h18);

        print_summary();
        $finish;
    end

endmodule